// File: doc/BRIEF.md
# Ingress Station-Address and Length Frame Filter

This block watches received Ethernet frames as they pass on a byte-wide stream. Each frame is bounded by a start marker on its first byte and an end marker on its last byte. The block compares the six destination bytes with a programmed station address and counts the frame's bytes. One cycle after the last byte, it gives a single verdict: accept or drop. Drops are counted in two saturating counters, one for address misses and one for length violations. The frame body is not stored. A downstream buffer uses the verdict to commit or discard the bytes it has already taken.

The stream port is valid/ready. The filter only observes the stream and never stalls it, so `s_ready` is held high and there is no back-pressure. Every cycle with `s_valid` high is one byte. A frame opens on a byte with `s_first` set. Bytes that arrive outside an open frame are ignored.

Four 32-bit configuration words are written through a plain write strobe. The frame check always uses a snapshot of these words. The snapshot is refreshed only on cycles when no frame is open and no frame is starting.

Top module: `rx_station_filter`

## Requirements
- R1: `s_ready` is always 1. A byte counts only while a frame is open or when it carries `s_first`. A valid byte without `s_first` while no frame is open gives no verdict and changes no counter. Idle cycles inside a frame are allowed.
- R2: When control word bit 28 is 0 (pass-all), any destination address is accepted. Length limits still apply.
- R3: When bit 28 is 1, a frame whose destination bytes 0..5 (byte 0 received first) equal the station address is accepted. Word select 0 holds bytes 0..3, with byte 0 in bits 7:0. Word select 1 holds byte 4 in bits 23:16 and byte 5 in bits 31:24.
- R4: When bit 28 is 1, the destination FF:FF:FF:FF:FF:FF is accepted.
- R5: When bit 28 is 1, any other destination is dropped and `drop_addr_cnt` goes up by one. A frame shorter than 6 bytes never matches an address.
- R6: A frame with fewer bytes than the undersize limit is dropped and `drop_len_cnt` goes up by one. The undersize limit is bits 31:16 of word select 3.
- R7: A frame with more bytes than the maximum payload plus 18 is dropped and counted in `drop_len_cnt`. The maximum payload is bits 15:0 of word select 3. A frame of exactly the maximum payload plus 18 bytes passes.
- R8: When a frame breaks both the length and the address rules, it is counted only in `drop_len_cnt`.
- R9: Each frame gives exactly one one-cycle pulse on `frame_accept` or `frame_drop`, in the cycle after its last byte. The two pulses are never high together.
- R10: Each drop counter increments in the cycle after its drop pulse and holds at its maximum value.
- R11: A configuration write made while a frame is open, or in the cycle a frame starts, has no effect on that frame. It applies to the next frame.
- R12: After reset, both counters are 0, pass-all mode is on, the undersize limit is 64 and the maximum payload is 1500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Always 1; the filter never stalls the stream |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Marks the first byte of a frame |
| s_last | input | 1 | Marks the last byte of a frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 address low, 1 address high, 2 control, 3 length limits |
| cfg_wdata | input | 32 | Configuration write data |
| frame_accept | output | 1 | One-cycle accept verdict |
| frame_drop | output | 1 | One-cycle drop verdict |
| drop_addr_cnt | output | CNT_W | Saturating count of address drops |
| drop_len_cnt | output | CNT_W | Saturating count of length drops |

## Verification
The assertions assume that `s_first` and `s_last` carry meaning only together with `s_valid`. They also assume that the stream source never holds a byte back, since `s_ready` is constant. The pulse-origin check traces each verdict back to a valid byte marked last in the previous cycle. It therefore relies on every frame end being a real `s_valid` byte. The stimulus drives all inputs between clock edges and raises the markers only on valid bytes. Configuration writes are issued at frame edges, mid-frame and on idle cycles, so the snapshot rule is exercised under all three.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  localparam int ADDR_BYTES     = 6;
  localparam int FRAME_OVERHEAD = 18;
  localparam int LEN_W          = 16;
  localparam int FILT_EN_BIT    = 28;
  localparam logic [15:0] MIN_LEN_RST = 16'd64;
  localparam logic [15:0] MAX_PAY_RST = 16'd1500;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_LEN     = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [8*ADDR_BYTES-1:0] station;
    logic                    filt_en;
    logic [LEN_W-1:0]        min_len;
    logic [LEN_W-1:0]        max_pay;
  } filt_cfg_t;
endpackage

// File: rtl/rsf_cfg.sv
module rsf_cfg
  import rsf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        busy,
  output filt_cfg_t   act
);
  logic [31:0] lo_q, lo_d;
  logic [15:0] hi_q, hi_d;
  logic        en_q, en_d;
  logic [31:0] len_q, len_d;
  filt_cfg_t   act_q;

  // Shadow words merged with this cycle's write
  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    en_d  = en_q;
    len_d = len_q;
    if (cfg_we) begin
      unique case (cfg_sel_e'(cfg_sel))
        SEL_ADDR_LO: lo_d  = cfg_wdata;
        SEL_ADDR_HI: hi_d  = cfg_wdata[31:16];
        SEL_CTRL:    en_d  = cfg_wdata[FILT_EN_BIT];
        SEL_LEN:     len_d = cfg_wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      en_q  <= 1'b0;
      len_q <= {MIN_LEN_RST, MAX_PAY_RST};
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      en_q  <= en_d;
      len_q <= len_d;
    end
  end

  // Snapshot refreshed only between frames
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '{station: '0, filt_en: 1'b0, min_len: MIN_LEN_RST, max_pay: MAX_PAY_RST};
    end else if (!busy) begin
      act_q <= '{station: {hi_d, lo_d}, filt_en: en_d,
                 min_len: len_d[31:16], max_pay: len_d[15:0]};
    end
  end

  assign act = act_q;
endmodule

// File: rtl/rsf_len.sv
module rsf_len
  import rsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  input  logic [LEN_W-1:0] min_len,
  input  logic [LEN_W-1:0] max_pay,
  output logic [LEN_W-1:0] idx,
  output logic             len_short,
  output logic             len_long
);
  localparam logic [LEN_W-1:0] CNT_TOP = '1;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W:0]   total;
  logic [LEN_W:0]   upper;

  assign idx       = first ? '0 : cnt_q;
  assign total     = {1'b0, idx} + (LEN_W+1)'(1);
  assign upper     = {1'b0, max_pay} + (LEN_W+1)'(FRAME_OVERHEAD);
  assign len_short = total < {1'b0, min_len};
  assign len_long  = total > upper;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (beat && idx != CNT_TOP) cnt_q <= idx + LEN_W'(1);
    else if (beat)                   cnt_q <= idx;
  end

  // R7: the byte counter holds at its top instead of wrapping
  p_len_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first && cnt_q == CNT_TOP) |=> cnt_q == CNT_TOP);
endmodule

// File: rtl/rsf_addr.sv
module rsf_addr
  import rsf_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first,
  input  logic [LEN_W-1:0]        idx,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    addr_hit
);
  localparam int SW = $clog2(ADDR_BYTES);
  localparam int NB = 1 << SW;

  logic [7:0] sta_b [NB];
  for (genvar g = 0; g < NB; g++) begin : g_byte
    if (g < ADDR_BYTES) begin : g_real
      assign sta_b[g] = station[8*g +: 8];
    end else begin : g_pad
      assign sta_b[g] = '0;
    end
  end

  logic uc_q, bc_q, uc_run, bc_run, uc_n, bc_n, in_hdr, full;
  logic [7:0] ref_b;

  assign in_hdr = idx < LEN_W'(ADDR_BYTES);
  assign full   = idx >= LEN_W'(ADDR_BYTES - 1);
  assign ref_b  = sta_b[idx[SW-1:0]];
  assign uc_run = first | uc_q;
  assign bc_run = first | bc_q;
  assign uc_n   = in_hdr ? (uc_run & (data == ref_b)) : uc_run;
  assign bc_n   = in_hdr ? (bc_run & (data == 8'hFF)) : bc_run;
  assign addr_hit = full & (uc_n | bc_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_q <= 1'b0;
      bc_q <= 1'b0;
    end else if (beat) begin
      uc_q <= uc_n;
      bc_q <= bc_n;
    end
  end
endmodule

// File: rtl/rx_station_filter.sv
module rx_station_filter
  import rsf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic             frame_accept,
  output logic             frame_drop,
  output logic [CNT_W-1:0] drop_addr_cnt,
  output logic [CNT_W-1:0] drop_len_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  filt_cfg_t        act;
  logic             in_frame_q, beat, busy, frame_end;
  logic [LEN_W-1:0] idx;
  logic             len_short, len_long, len_bad, addr_hit, addr_bad;
  logic             acc_q, drop_q, cause_len_q;
  logic [CNT_W-1:0] cnt_a_q, cnt_l_q;

  assign s_ready   = 1'b1;
  assign beat      = s_valid & (s_first | in_frame_q);
  assign busy      = in_frame_q | (s_valid & s_first);
  assign frame_end = beat & s_last;

  rsf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .act(act)
  );

  rsf_len u_len (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(s_first),
    .min_len(act.min_len), .max_pay(act.max_pay),
    .idx(idx), .len_short(len_short), .len_long(len_long)
  );

  rsf_addr u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(s_first), .idx(idx),
    .data(s_data), .station(act.station), .addr_hit(addr_hit)
  );

  assign len_bad  = len_short | len_long;
  assign addr_bad = act.filt_en & ~addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      acc_q       <= 1'b0;
      drop_q      <= 1'b0;
      cause_len_q <= 1'b0;
    end else begin
      if (beat) in_frame_q <= ~s_last;
      acc_q       <= frame_end & ~len_bad & ~addr_bad;
      drop_q      <= frame_end & (len_bad | addr_bad);
      cause_len_q <= len_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a_q <= '0;
      cnt_l_q <= '0;
    end else if (drop_q) begin
      if (cause_len_q && cnt_l_q != CNT_MAX)       cnt_l_q <= cnt_l_q + CNT_W'(1);
      else if (!cause_len_q && cnt_a_q != CNT_MAX) cnt_a_q <= cnt_a_q + CNT_W'(1);
    end
  end

  assign frame_accept  = acc_q;
  assign frame_drop    = drop_q;
  assign drop_addr_cnt = cnt_a_q;
  assign drop_len_cnt  = cnt_l_q;

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_accept && frame_drop));
  p_verdict_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_accept || frame_drop) |-> $past(s_valid && s_last));
  p_len_cnt_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_len_cnt >= $past(drop_len_cnt));
  p_addr_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_addr_cnt != $past(drop_addr_cnt)) |-> $past(frame_drop));
endmodule

// File: tb/sim_rx_station_filter.sv
`timescale 1ns/1ps
module sim_rx_station_filter;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_first = 0, s_last = 0, cfg_we = 0;
  logic [7:0] s_data = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic s_ready, frame_accept, frame_drop;
  logic [CW-1:0] drop_addr_cnt, drop_len_cnt;

  always #2.5 clk = ~clk;

  rx_station_filter #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .frame_accept(frame_accept),
    .frame_drop(frame_drop), .drop_addr_cnt(drop_addr_cnt), .drop_len_cnt(drop_len_cnt)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] sh_lo, sh_hi, sh_len, ac_lo, ac_hi, ac_len;
  bit sh_en, ac_en, m_in;
  byte unsigned fq[$];
  bit e_acc, e_drop, e_len;
  int e_ca, e_cl;
  string e_tag = "R9";

  function automatic byte unsigned sta_byte(input int i);
    if (i < 4) return ac_lo[8*i +: 8];
    return ac_hi[16 + 8*(i-4) +: 8];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sh_lo = 0; sh_hi = 0; sh_en = 0; sh_len = {16'd64, 16'd1500};
      ac_lo = 0; ac_hi = 0; ac_en = 0; ac_len = sh_len;
      m_in = 0; e_acc = 0; e_drop = 0; e_len = 0; e_ca = 0; e_cl = 0;
      fq.delete();
    end else begin
      bit busy;
      if (e_drop) begin
        if (e_len) begin if (e_cl < CMAX) e_cl++; end
        else begin if (e_ca < CMAX) e_ca++; end
      end
      e_acc = 0; e_drop = 0;
      busy = m_in || (s_valid && s_first);
      if (s_valid && (s_first || m_in)) begin
        if (s_first) fq.delete();
        fq.push_back(s_data);
        if (s_last) begin
          int n;
          bit uc, bc, shrt, lng, abad;
          n = fq.size();
          uc = (n >= 6); bc = (n >= 6);
          for (int i = 0; i < 6 && i < n; i++) begin
            if (fq[i] != sta_byte(i)) uc = 0;
            if (fq[i] != 8'hFF) bc = 0;
          end
          shrt = n < int'(ac_len[31:16]);
          lng  = n > int'(ac_len[15:0]) + 18;
          abad = ac_en && !(uc || bc);
          if (shrt || lng) begin
            e_drop = 1; e_len = 1;
            e_tag = abad ? "R8" : (shrt ? "R6" : "R7");
          end else if (abad) begin
            e_drop = 1; e_len = 0; e_tag = "R5";
          end else begin
            e_acc = 1; e_tag = !ac_en ? "R2" : (uc ? "R3" : "R4");
          end
          m_in = 0;
        end else m_in = 1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: sh_lo = cfg_wdata;
          2'd1: sh_hi = {cfg_wdata[31:16], 16'h0};
          2'd2: sh_en = cfg_wdata[28];
          default: sh_len = cfg_wdata;
        endcase
      end
      if (!busy) begin ac_lo = sh_lo; ac_hi = sh_hi; ac_en = sh_en; ac_len = sh_len; end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int pulses = 0;
  bit last_res = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(frame_accept == e_acc && frame_drop == e_drop, {e_tag, "/R9 verdict"},
            {frame_accept, frame_drop}, {e_acc, e_drop});
      check(int'(drop_addr_cnt) == e_ca, "R5/R10 addr count", drop_addr_cnt, e_ca);
      check(int'(drop_len_cnt) == e_cl, "R6/R10 len count", drop_len_cnt, e_cl);
      check(s_ready == 1'b1, "R1 ready", s_ready, 1);
      if (frame_accept) begin pulses++; last_res = 1; end
      if (frame_drop)   begin pulses++; last_res = 0; end
    end
  end

  // ---------------- stimulus ----------------
  int wr_at = -1;
  logic [1:0] wr_sel;
  logic [31:0] wr_data;

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send_frame(input logic [47:0] da, input int n, input bit gap);
    for (int k = 0; k < n; k++) begin
      if (gap && k % 2 == 1) begin
        @(negedge clk); s_valid = 0; s_first = 0; s_last = 0; cfg_we = 0;
      end
      @(negedge clk);
      s_valid = 1; s_first = (k == 0); s_last = (k == n - 1);
      s_data = (k < 6) ? da[8*k +: 8] : 8'(k);
      cfg_we = (k == wr_at);
      if (k == wr_at) begin cfg_sel = wr_sel; cfg_wdata = wr_data; end
    end
    @(negedge clk); s_valid = 0; s_first = 0; s_last = 0; cfg_we = 0;
    wr_at = -1;
  endtask

  task automatic run_frame(input logic [47:0] da, input int n, input bit gap,
                           input bit exp_acc, input string tag);
    int p0;
    p0 = pulses;
    send_frame(da, n, gap);
    @(negedge clk); @(negedge clk);
    check(pulses == p0 + 1, {tag, " one verdict"}, pulses - p0, 1);
    check(last_res == exp_acc, {tag, " verdict"}, last_res, exp_acc);
  endtask

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OTHER = 48'h0A0B_0C0D_0E0F;

  initial begin
    int c0, p0;
    repeat (4) @(negedge clk);
    check(drop_addr_cnt == 0 && drop_len_cnt == 0, "R12 counters at reset",
          drop_addr_cnt + drop_len_cnt, 0);
    check(frame_accept == 0 && frame_drop == 0, "R12 no pulse in reset",
          frame_accept + frame_drop, 0);
    rst_n = 1;
    @(negedge clk);

    // R12 defaults: pass-all, 64..1518
    run_frame(OTHER, 63, 0, 0, "R12 undersize default");
    run_frame(OTHER, 64, 0, 1, "R12 min default pass-all");
    run_frame(OTHER, 1518, 0, 1, "R7 max+18 default");
    run_frame(OTHER, 1519, 0, 0, "R7 over max default");

    // R1 stray bytes outside a frame
    p0 = pulses; c0 = drop_len_cnt + drop_addr_cnt;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); s_valid = 1; s_last = 1; s_data = 8'h33;
    end
    @(negedge clk); s_valid = 0; s_last = 0;
    repeat (3) @(negedge clk);
    check(pulses == p0, "R1 stray bytes ignored", pulses - p0, 0);
    check(int'(drop_len_cnt + drop_addr_cnt) == c0, "R1 counters unchanged",
          drop_len_cnt + drop_addr_cnt, c0);

    // R3/R4/R5 station filtering
    cfg_write(2'd0, 32'h3322_1102);
    cfg_write(2'd1, 32'h5544_0000);
    cfg_write(2'd2, 32'h1000_0000);
    run_frame(STA, 64, 0, 1, "R3 station match");
    run_frame(STA, 70, 1, 1, "R1 gaps inside frame");
    run_frame(BCAST, 64, 0, 1, "R4 broadcast");
    c0 = drop_addr_cnt;
    run_frame(48'h5544_3322_1103, 64, 0, 0, "R5 byte0 differs");
    run_frame(48'h5644_3322_1102, 64, 0, 0, "R5 byte5 differs");
    check(int'(drop_addr_cnt) == c0 + 2, "R5 addr drops counted", drop_addr_cnt, c0 + 2);
    run_frame(48'h4455_3322_1102, 64, 0, 0, "R3 byte order");

    // R6/R7/R8 with small limits: min 8, max payload 2 -> 20 bytes
    cfg_write(2'd3, {16'd8, 16'd2});
    run_frame(STA, 20, 0, 1, "R7 exactly max+18");
    run_frame(STA, 21, 0, 0, "R7 one over");
    run_frame(STA, 8, 0, 1, "R6 exactly min");
    run_frame(STA, 7, 0, 0, "R6 one under");
    c0 = drop_addr_cnt;
    run_frame(OTHER, 7, 0, 0, "R8 both faults");
    check(drop_addr_cnt == c0, "R8 addr count untouched", drop_addr_cnt, c0);

    // R2 pass-all
    cfg_write(2'd2, 32'h0);
    run_frame(OTHER, 10, 0, 1, "R2 pass-all");
    cfg_write(2'd2, 32'h1000_0000);

    // R11 writes deferred to frame boundary
    wr_at = 3; wr_sel = 2'd0; wr_data = 32'h3322_11AA;
    run_frame(STA, 12, 0, 1, "R11 addr write mid-frame");
    run_frame(STA, 12, 0, 0, "R11 new addr applies");
    cfg_write(2'd0, 32'h3322_1102);
    wr_at = 0; wr_sel = 2'd3; wr_data = {16'd16, 16'd2};
    run_frame(STA, 10, 0, 1, "R11 len write on first byte");
    run_frame(STA, 10, 0, 0, "R11 new min applies");

    // R10 saturation
    for (int f = 0; f < 20; f++) send_frame(STA, 3, 0);
    repeat (3) @(negedge clk);
    check(int'(drop_len_cnt) == CMAX, "R10 saturated", drop_len_cnt, CMAX);
    run_frame(STA, 3, 0, 0, "R10 drop at saturation");
    check(int'(drop_len_cnt) == CMAX, "R10 holds", drop_len_cnt, CMAX);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule